// File: doc/BRIEF.md
# Vector Register File with Run-Time Element Packing

This block holds the architectural vector state of a vector unit: thirty-two registers of VLEN bits each, reached one element at a time. The element width is picked every cycle from a two-bit width code. A length input bounds which element indices are live. Narrow elements sit inside ELEN-bit units with the lowest index at the lowest bits, and the units in turn sit inside the register the same way. Element `i` of width `W` therefore begins at bit `i*W`.

Two combinational read ports and one clocked write port each name a register and an element index. A wide-operand mode doubles the element width and spreads a vector over an even/odd register pair. Even-indexed elements live in the even register and odd-indexed elements in the odd one, each at slot `i>>1`. Configurations that cannot be represented raise an illegal flag, and writes made under them are dropped.

Top module: `vec_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears every register, so after reset every legal read returns zero.
- R2: Width code `elem_w` selects SEW as 0=8, 1=16, 2=32, 3=64 bits, and a read returns the selected element zero-extended to ELEN bits.
- R3: Element `i` of width `W` occupies register bits `[i*W +: W]`. This is unit `i/(ELEN/W)` at bits `[unit*ELEN +: ELEN]`, and within that unit it sits at position `(i mod (ELEN/W))*W`.
- R4: An element index at or above `vlen_act` reads as zero on both read ports, and a write to such an index leaves the register unchanged.
- R5: A write changes only the addressed element's bits on the rising clock edge; all other bits keep their values.
- R6: With `pair_mode` high, the element width is 2×SEW and element `i` of base register `b` lives in register `b+(i&1)` at slot `i>>1`.
- R7: With `pair_mode` high and an odd write register, `wr_illegal` is 1 and the write is dropped. A read whose register is odd in pair mode returns zero.
- R8: When the effective element width exceeds ELEN (pair mode with code 3), `wr_illegal` is 1, writes are dropped and reads return zero.
- R9: An index whose slot lies at or beyond VLEN/width reads as zero, and a write to it is dropped.
- R10: The two read ports resolve independently and combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| elem_w | input | 2 | Element width code |
| pair_mode | input | 1 | Wide-operand (register pair) mode |
| vlen_act | input | 5 | Number of live elements |
| rd_a_reg | input | 5 | Read port A register |
| rd_a_idx | input | 5 | Read port A element index |
| rd_a_data | output | 64 | Read port A element, zero-extended |
| rd_b_reg | input | 5 | Read port B register |
| rd_b_idx | input | 5 | Read port B element index |
| rd_b_data | output | 64 | Read port B element, zero-extended |
| wr_en | input | 1 | Write enable |
| wr_reg | input | 5 | Write register |
| wr_idx | input | 5 | Write element index |
| wr_data | input | 64 | Write data; only the low element-width bits are stored |
| wr_illegal | output | 1 | Configuration or write register not representable |

## Verification
The assertions assume that `elem_w`, `pair_mode` and `vlen_act` are known values whenever reset is low. They also assume that a read of a live element only sees bits that a legal write could have stored. The bench keeps to this by driving every control input from tasks on the falling edge, never leaving one undefined. It also releases reset only after all inputs hold defined values. The sweeps cover every width code, full, partial and zero lengths, and pair mode on even and odd bases. The expected element is taken from a bit-level model indexed by the R3 and R6 formulas.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
    typedef enum logic [1:0] {
        SEW_E8  = 2'd0,
        SEW_E16 = 2'd1,
        SEW_E32 = 2'd2,
        SEW_E64 = 2'd3
    } sew_code_e;

    // log2 of the effective element width in bits
    function automatic logic [31:0] width_log2(input logic [1:0] code, input logic pair);
        return 32'd3 + {30'd0, code} + {31'd0, pair};
    endfunction
endpackage

// File: rtl/vrf_locate.sv
module vrf_locate #(
    parameter int NREG = 32,
    parameter int VLEN = 128,
    parameter int ELEN = 64
) (
    input  logic [1:0]                      elem_w,
    input  logic                            pair_mode,
    input  logic [$clog2(VLEN/8):0]         vlen_act,
    input  logic [$clog2(NREG)-1:0]         areg,
    input  logic [$clog2(VLEN/8):0]         idx,
    output logic [$clog2(NREG)-1:0]         phys,
    output logic [$clog2(VLEN)-1:0]         lsb,
    output logic [ELEN-1:0]                 mask,
    output logic                            ok,
    output logic                            cfg_bad
);
    localparam int OW       = $clog2(VLEN);
    localparam int LOG_ELEN = $clog2(ELEN);

    logic [31:0] lw, slot, slots, per_log, unit_n, sub_n, pos;

    always_comb begin
        lw      = vrf_pkg::width_log2(elem_w, pair_mode);
        cfg_bad = (lw > 32'(LOG_ELEN));
        slot    = pair_mode ? (32'(idx) >> 1) : 32'(idx);
        slots   = cfg_bad ? 32'd0 : (32'(VLEN) >> lw);
        per_log = cfg_bad ? 32'd0 : (32'(LOG_ELEN) - lw);
        unit_n  = slot >> per_log;
        sub_n   = slot & ((32'd1 << per_log) - 32'd1);
        pos     = unit_n * 32'(ELEN) + (sub_n << lw);
        lsb     = pos[OW-1:0];
        phys    = pair_mode ? {areg[$clog2(NREG)-1:1], idx[0]} : areg;
        ok      = !cfg_bad && (idx < vlen_act) && (slot < slots) && !(pair_mode && areg[0]);
        mask    = cfg_bad ? '0 : ({ELEN{1'b1}} >> (32'(ELEN) - (32'd1 << lw)));
    end
endmodule

// File: rtl/vrf_read_lane.sv
module vrf_read_lane #(
    parameter int VLEN = 128,
    parameter int ELEN = 64
) (
    input  logic [VLEN-1:0]         word,
    input  logic [$clog2(VLEN)-1:0] lsb,
    input  logic [ELEN-1:0]         mask,
    input  logic                    ok,
    output logic [ELEN-1:0]         data
);
    logic [VLEN-1:0] shifted;

    always_comb begin
        shifted = word >> lsb;
        data    = ok ? (shifted[ELEN-1:0] & mask) : '0;
    end
endmodule

// File: rtl/vec_regfile.sv
module vec_regfile #(
    parameter int NREG = 32,
    parameter int VLEN = 128,
    parameter int ELEN = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [1:0]                  elem_w,
    input  logic                        pair_mode,
    input  logic [$clog2(VLEN/8):0]     vlen_act,
    input  logic [$clog2(NREG)-1:0]     rd_a_reg,
    input  logic [$clog2(VLEN/8):0]     rd_a_idx,
    output logic [ELEN-1:0]             rd_a_data,
    input  logic [$clog2(NREG)-1:0]     rd_b_reg,
    input  logic [$clog2(VLEN/8):0]     rd_b_idx,
    output logic [ELEN-1:0]             rd_b_data,
    input  logic                        wr_en,
    input  logic [$clog2(NREG)-1:0]     wr_reg,
    input  logic [$clog2(VLEN/8):0]     wr_idx,
    input  logic [ELEN-1:0]             wr_data,
    output logic                        wr_illegal
);
    localparam int RW = $clog2(NREG);
    localparam int CW = $clog2(VLEN/8) + 1;
    localparam int OW = $clog2(VLEN);
    localparam int NRP = 2;

    logic [VLEN-1:0] regs [NREG];

    logic [RW-1:0]   rp_reg  [NRP];
    logic [CW-1:0]   rp_idx  [NRP];
    logic [ELEN-1:0] rp_data [NRP];

    assign rp_reg[0] = rd_a_reg;
    assign rp_idx[0] = rd_a_idx;
    assign rp_reg[1] = rd_b_reg;
    assign rp_idx[1] = rd_b_idx;
    assign rd_a_data = rp_data[0];
    assign rd_b_data = rp_data[1];

    for (genvar p = 0; p < NRP; p++) begin : g_rport
        logic [RW-1:0]   phys;
        logic [OW-1:0]   lsb;
        logic [ELEN-1:0] mask;
        logic            ok;
        logic            bad_unused;

        vrf_locate #(.NREG(NREG), .VLEN(VLEN), .ELEN(ELEN)) i_loc (
            .elem_w    (elem_w),
            .pair_mode (pair_mode),
            .vlen_act  (vlen_act),
            .areg      (rp_reg[p]),
            .idx       (rp_idx[p]),
            .phys      (phys),
            .lsb       (lsb),
            .mask      (mask),
            .ok        (ok),
            .cfg_bad   (bad_unused)
        );

        vrf_read_lane #(.VLEN(VLEN), .ELEN(ELEN)) i_lane (
            .word (regs[phys]),
            .lsb  (lsb),
            .mask (mask),
            .ok   (ok),
            .data (rp_data[p])
        );
    end

    logic [RW-1:0]   w_phys;
    logic [OW-1:0]   w_lsb;
    logic [ELEN-1:0] w_mask;
    logic            w_ok;
    logic            w_bad;
    logic [VLEN-1:0] w_hole;
    logic [VLEN-1:0] w_bits;

    vrf_locate #(.NREG(NREG), .VLEN(VLEN), .ELEN(ELEN)) i_wloc (
        .elem_w    (elem_w),
        .pair_mode (pair_mode),
        .vlen_act  (vlen_act),
        .areg      (wr_reg),
        .idx       (wr_idx),
        .phys      (w_phys),
        .lsb       (w_lsb),
        .mask      (w_mask),
        .ok        (w_ok),
        .cfg_bad   (w_bad)
    );

    assign wr_illegal = w_bad || (pair_mode && wr_reg[0]);
    assign w_hole     = ~(VLEN'(w_mask) << w_lsb);
    assign w_bits     = VLEN'(wr_data & w_mask) << w_lsb;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) regs[r] <= '0;
        end else if (wr_en && w_ok) begin
            regs[w_phys] <= (regs[w_phys] & w_hole) | w_bits;
        end
    end
endmodule

// File: rtl/vrf_checker.sv
module vrf_checker #(
    parameter int NREG = 32,
    parameter int VLEN = 128,
    parameter int ELEN = 64
) (
    input logic                    clk,
    input logic                    rst,
    input logic [1:0]              elem_w,
    input logic                    pair_mode,
    input logic [$clog2(VLEN/8):0] vlen_act,
    input logic [$clog2(NREG)-1:0] rd_a_reg,
    input logic [$clog2(VLEN/8):0] rd_a_idx,
    input logic [ELEN-1:0]         rd_a_data,
    input logic [$clog2(VLEN/8):0] rd_b_idx,
    input logic [ELEN-1:0]         rd_b_data,
    input logic                    wr_illegal
);
    localparam int LOG_ELEN = $clog2(ELEN);

    logic [31:0] eff_log;
    assign eff_log = vrf_pkg::width_log2(elem_w, pair_mode);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (rd_a_data == '0 && rd_b_data == '0));

    p_zero_ext_r2: assert property (@(posedge clk) disable iff (rst)
        (!pair_mode && eff_log < 32'(LOG_ELEN)) |->
        ((rd_a_data >> (32'd1 << eff_log)) == '0));

    p_beyond_len_a_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx >= vlen_act) |-> (rd_a_data == '0));

    p_beyond_len_b_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_b_idx >= vlen_act) |-> (rd_b_data == '0));

    p_odd_pair_read_r7: assert property (@(posedge clk) disable iff (rst)
        (pair_mode && rd_a_reg[0]) |-> (rd_a_data == '0));

    p_too_wide_r8: assert property (@(posedge clk) disable iff (rst)
        (eff_log > 32'(LOG_ELEN)) |-> (wr_illegal && rd_a_data == '0 && rd_b_data == '0));
endmodule

bind vec_regfile vrf_checker #(.NREG(NREG), .VLEN(VLEN), .ELEN(ELEN)) i_vrf_checker (
    .clk        (clk),
    .rst        (rst),
    .elem_w     (elem_w),
    .pair_mode  (pair_mode),
    .vlen_act   (vlen_act),
    .rd_a_reg   (rd_a_reg),
    .rd_a_idx   (rd_a_idx),
    .rd_a_data  (rd_a_data),
    .rd_b_idx   (rd_b_idx),
    .rd_b_data  (rd_b_data),
    .wr_illegal (wr_illegal)
);

// File: tb/test_vec_regfile.sv
module test_vec_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 32;
    localparam int VLEN = 128;
    localparam int ELEN = 64;
    localparam int CW   = $clog2(VLEN/8) + 1;

    logic            clk = 1'b0;
    logic            rst;
    logic [1:0]      elem_w;
    logic            pair_mode;
    logic [CW-1:0]   vlen_act;
    logic [4:0]      rd_a_reg, rd_b_reg;
    logic [CW-1:0]   rd_a_idx, rd_b_idx;
    logic [ELEN-1:0] rd_a_data, rd_b_data;
    logic            wr_en;
    logic [4:0]      wr_reg;
    logic [CW-1:0]   wr_idx;
    logic [ELEN-1:0] wr_data;
    logic            wr_illegal;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [VLEN-1:0] model [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_regfile #(.NREG(NREG), .VLEN(VLEN), .ELEN(ELEN)) i_vec_regfile (
        .clk(clk), .rst(rst), .elem_w(elem_w), .pair_mode(pair_mode), .vlen_act(vlen_act),
        .rd_a_reg(rd_a_reg), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_reg(rd_b_reg), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_illegal(wr_illegal)
    );

    // Placement from R3/R6: element i of width W at bits i'*W of register r'.
    function automatic bit locate(input int areg, input int idx, output int phys,
                                  output int lsb, output int w);
        int lw = 3 + int'(elem_w) + int'(pair_mode);
        int slot;
        w    = 1 << lw;
        slot = pair_mode ? (idx >> 1) : idx;
        phys = pair_mode ? ((areg & ~1) | (idx & 1)) : areg;
        lsb  = slot * w;
        if (w > ELEN) return 0;
        if (pair_mode && (areg & 1)) return 0;
        if (idx >= int'(vlen_act)) return 0;
        if (slot >= VLEN / w) return 0;
        return 1;
    endfunction

    function automatic logic [ELEN-1:0] mdl_read(input int areg, input int idx);
        int phys, lsb, w;
        logic [ELEN-1:0] v = '0;
        if (!locate(areg, idx, phys, lsb, w)) return '0;
        for (int b = 0; b < w; b++) v[b] = model[phys][lsb + b];
        return v;
    endfunction

    task automatic check(input string req, input logic [ELEN-1:0] act, input logic [ELEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input int r, input int idx, input logic [ELEN-1:0] d);
        int phys, lsb, w;
        @(negedge clk);
        wr_en = 1'b1; wr_reg = 5'(r); wr_idx = CW'(idx); wr_data = d;
        if (locate(r, idx, phys, lsb, w))
            for (int b = 0; b < w; b++) model[phys][lsb + b] = d[b];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input int ra, input int ia, input int rb, input int ib);
        rd_a_reg = 5'(ra); rd_a_idx = CW'(ia);
        rd_b_reg = 5'(rb); rd_b_idx = CW'(ib);
        #1;
        check(req, rd_a_data, mdl_read(ra, ia));
        check(req, rd_b_data, mdl_read(rb, ib));
    endtask

    task automatic set_cfg(input int code, input bit pair, input int len);
        elem_w = 2'(code); pair_mode = pair; vlen_act = CW'(len);
    endtask

    // Raw register image read as 64-bit units, compared to the model (R3)
    task automatic dump_check(input string req, input int r);
        logic [1:0] sw = elem_w; logic sp = pair_mode; logic [CW-1:0] sl = vlen_act;
        set_cfg(3, 0, VLEN / 64);
        for (int u = 0; u < VLEN / 64; u++) begin
            rd_a_reg = 5'(r); rd_a_idx = CW'(u); rd_b_reg = 5'(r); rd_b_idx = CW'(u);
            #1;
            check(req, rd_a_data, model[r][u*64 +: 64]);
        end
        elem_w = sw; pair_mode = sp; vlen_act = sl;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NREG; r++) model[r] = '0;
        rst = 1'b1; wr_en = 1'b0; wr_reg = '0; wr_idx = '0; wr_data = '0;
        rd_a_reg = '0; rd_a_idx = '0; rd_b_reg = '0; rd_b_idx = '0;
        set_cfg(0, 0, 16);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: everything zero after reset
        for (int r = 0; r < NREG; r += 5) rd_check("R1 reset", r, r % 16, r + 1, 15);

        // R2/R3/R5/R10: every width code, full length
        for (int s = 0; s < 4; s++) begin
            int w = 8 << s;
            int n = VLEN / w;
            set_cfg(s, 0, n);
            for (int i = 0; i < n; i++)
                do_write(s + 1, i, 64'h0123_4567_89AB_CDEF * (i + 1) + 64'(s * 977));
            @(negedge clk);
            for (int i = 0; i < n; i++) rd_check("R2 R10 element", s + 1, i, s + 1, n - 1 - i);
            dump_check("R3 packing", s + 1);
            check("R2 legal flag", {63'd0, wr_illegal}, 64'd0);
        end

        // R4/R5: partial length
        set_cfg(0, 0, 16);
        for (int i = 0; i < 16; i++) do_write(10, i, 64'(8'hC0 + i));
        set_cfg(0, 0, 5);
        do_write(10, 3, 64'h5A);
        do_write(10, 7, 64'hEE);
        @(negedge clk);
        rd_check("R4 beyond vl", 10, 7, 10, 3);
        set_cfg(0, 0, 16);
        rd_check("R4 R5 untouched", 10, 7, 10, 4);
        dump_check("R5 neighbours", 10);

        // R4: zero length
        set_cfg(1, 0, 0);
        do_write(1, 0, 64'hFFFF);
        rd_check("R4 vl zero", 1, 0, 2, 1);
        dump_check("R4 vl zero image", 1);

        // R6: pair mode, 2*16-bit elements over regs 12/13
        set_cfg(1, 1, 8);
        for (int i = 0; i < 8; i++) do_write(12, i, 64'hDEAD_0000 + 64'(i * 4369));
        @(negedge clk);
        for (int i = 0; i < 8; i++) rd_check("R6 pair read", 12, i, 12, 7 - i);
        dump_check("R6 even reg", 12);
        dump_check("R6 odd reg", 13);

        // R7: odd base
        set_cfg(1, 1, 8);
        wr_reg = 5'd13; #1;
        check("R7 illegal flag", {63'd0, wr_illegal}, 64'd1);
        do_write(13, 1, 64'h1111_2222);
        rd_check("R7 odd read", 13, 0, 13, 1);
        dump_check("R7 odd unchanged", 13);

        // R8: effective width too large
        set_cfg(3, 1, 2);
        wr_reg = 5'd4; #1;
        check("R8 illegal flag", {63'd0, wr_illegal}, 64'd1);
        do_write(4, 0, 64'hFACE);
        rd_check("R8 read zero", 4, 0, 4, 1);
        dump_check("R8 unchanged", 4);

        // R9: slot past register capacity
        set_cfg(3, 0, 16);
        do_write(20, 2, 64'hBEEF);
        rd_check("R9 beyond capacity", 4, 2, 20, 3);
        dump_check("R9 unchanged", 20);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule